// File: doc/BRIEF.md
# Address-Fault Interrupt Register Unit

This block is a small 32-bit register slave on an APB-style bus. It watches its own address decoder. Any access that does not land on one of its five word registers counts as an address fault, and the fault raises a sticky status flag. The flag drives a single level interrupt through a mask. Software never writes the mask directly. It clears mask bits by writing ones to an unmask strobe word and sets them by writing ones to a mask strobe word. It clears the status flag by writing one to it.

A control word chooses how a faulting access ends. With the error-response bit at 0, the access completes normally and a read returns zero. With the bit at 1, the access completes with PSLVERR high. Every access completes in its first access-phase cycle.

The register offsets are:

| Offset | Register |
|--------|----------|
| 0x0 | control |
| 0x4 | status |
| 0x8 | mask |
| 0xC | unmask strobe |
| 0x10 | mask strobe |

Top module: `addr_fault_irq_unit`

## Requirements
- R1: After a synchronous active-high reset the control word reads 0, the status word reads 0, the mask word reads 1 (source masked), and `irq` is 0.
- R2: Bit 0 of the control word at offset 0x0 can be read and written. All other bits of every register read as 0 and ignore writes.
- R3: An access is a fault when its offset is above 0x10 or when paddr[1:0] is not 0. A fault, whether a read or a write, sets status bit 0, which is read at offset 0x4.
- R4: Writing 1 to status bit 0 clears it. Writing 0 leaves it unchanged.
- R5: The mask word at offset 0x8 shows the mask in bit 0. A write to offset 0x8 does not change it.
- R6: Writing 1 to bit 0 at offset 0xC clears mask bit 0. Writing 0 has no effect, and offset 0xC always reads as 0.
- R7: Writing 1 to bit 0 at offset 0x10 sets mask bit 0. Offset 0x10 always reads as 0.
- R8: `irq` equals (status AND NOT mask) and is registered. It changes on the clock edge after the edge that changed status or mask.
- R9: During the access phase of a faulting access, `pslverr` equals control bit 0. A faulting read returns 0. `prdata` is 0 outside read access phases.
- R10: `pready` is high in every access phase, so there are no wait states.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | AW | Byte address (offset) |
| pwdata | input | DW | Write data |
| prdata | output | DW | Read data |
| pready | output | 1 | Transfer complete |
| pslverr | output | 1 | Error response for faulting access |
| irq | output | 1 | Level interrupt, registered |

## Verification
The bench first looks at the one-cycle lag of `irq`. It samples the output both in the cycle right after the status or mask edge and in the cycle after that, so a combinational interrupt would show up too early. The bench also writes zeros to the strobe words and writes directly to the mask word. A design that stored those writes, or treated them as level writes, would change the mask read back at 0x8. The misaligned address 0x3 is used to reach a fault that a range-only decoder would miss. Faults are run with the error-response bit at both values, so a design that drove `pslverr` without regard to the control word, or returned stale data on a faulting read, would be caught.

// File: rtl/addr_fault_pkg.sv
package addr_fault_pkg;
  localparam int unsigned NSRC = 1;

  // word indexes (offset >> 2)
  localparam int unsigned IDX_CTRL  = 0;
  localparam int unsigned IDX_STAT  = 1;
  localparam int unsigned IDX_MASK  = 2;
  localparam int unsigned IDX_UNMSK = 3;
  localparam int unsigned IDX_MSK   = 4;
  localparam int unsigned IDX_LAST  = IDX_MSK;

  typedef enum logic [2:0] {
    SEL_CTRL,
    SEL_STAT,
    SEL_MASK,
    SEL_UNMSK,
    SEL_MSK,
    SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/af_decode.sv
module af_decode
  import addr_fault_pkg::*;
#(
  parameter int unsigned AW = 12
) (
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  output logic          access,
  output logic          wr_access,
  output logic          fault,
  output reg_sel_e      sel
);
  localparam int unsigned IW = AW - 2;

  logic [IW-1:0] idx;
  logic          aligned;

  assign idx     = paddr[AW-1:2];
  assign aligned = (paddr[1:0] == 2'b00);

  always_comb begin
    sel = SEL_NONE;
    if (aligned) begin
      case (idx)
        IW'(IDX_CTRL):  sel = SEL_CTRL;
        IW'(IDX_STAT):  sel = SEL_STAT;
        IW'(IDX_MASK):  sel = SEL_MASK;
        IW'(IDX_UNMSK): sel = SEL_UNMSK;
        IW'(IDX_MSK):   sel = SEL_MSK;
        default:        sel = SEL_NONE;
      endcase
    end
  end

  assign access    = psel & penable;
  assign wr_access = access & pwrite;
  assign fault     = access & (sel == SEL_NONE);
endmodule

// File: rtl/af_irq_core.sv
module af_irq_core #(
  parameter int unsigned NSRC = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] evt,
  input  logic            stat_wr,
  input  logic            unmask_wr,
  input  logic            mask_wr,
  input  logic [NSRC-1:0] wbits,
  output logic [NSRC-1:0] status_q,
  output logic [NSRC-1:0] mask_q,
  output logic            irq_q
);
  genvar i;
  generate
    for (i = 0; i < NSRC; i++) begin : g_src
      always_ff @(posedge clk) begin
        if (rst) begin
          status_q[i] <= 1'b0;
        end else if (evt[i]) begin
          status_q[i] <= 1'b1;             // new event wins over clear
        end else if (stat_wr && wbits[i]) begin
          status_q[i] <= 1'b0;
        end
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          mask_q[i] <= 1'b1;
        end else if (unmask_wr && wbits[i]) begin
          mask_q[i] <= 1'b0;
        end else if (mask_wr && wbits[i]) begin
          mask_q[i] <= 1'b1;
        end
      end

      // R3
      evt_sets_chk: assert property (@(posedge clk) disable iff (rst)
        evt[i] |=> status_q[i]);
      // R6
      unmask_chk: assert property (@(posedge clk) disable iff (rst)
        (unmask_wr && wbits[i]) |=> !mask_q[i]);
      // R7
      mask_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_wr && wbits[i]) |=> mask_q[i]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(status_q & ~mask_q);
  end

  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(status_q != '0));
endmodule

// File: rtl/addr_fault_irq_unit.sv
module addr_fault_irq_unit
  import addr_fault_pkg::*;
#(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [DW-1:0] pwdata,
  output logic [DW-1:0] prdata,
  output logic          pready,
  output logic          pslverr,
  output logic          irq
);
  localparam logic [DW-1:0] CTRL_MASK = DW'(1);

  logic            access, wr_access, fault;
  reg_sel_e        sel;
  logic [DW-1:0]   ctrl_q;
  logic [NSRC-1:0] status_q, mask_q;
  logic            irq_q;

  af_decode #(.AW(AW)) u_dec (
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .access    (access),
    .wr_access (wr_access),
    .fault     (fault),
    .sel       (sel)
  );

  always_ff @(posedge clk) begin
    if (rst)                                ctrl_q <= '0;
    else if (wr_access && sel == SEL_CTRL)  ctrl_q <= pwdata & CTRL_MASK;
  end

  af_irq_core #(.NSRC(NSRC)) u_core (
    .clk       (clk),
    .rst       (rst),
    .evt       ({NSRC{fault}}),
    .stat_wr   (wr_access && sel == SEL_STAT),
    .unmask_wr (wr_access && sel == SEL_UNMSK),
    .mask_wr   (wr_access && sel == SEL_MSK),
    .wbits     (pwdata[NSRC-1:0]),
    .status_q  (status_q),
    .mask_q    (mask_q),
    .irq_q     (irq_q)
  );

  always_comb begin
    prdata = '0;
    if (access && !pwrite) begin
      case (sel)
        SEL_CTRL: prdata = ctrl_q;
        SEL_STAT: prdata = DW'(status_q);
        SEL_MASK: prdata = DW'(mask_q);
        default:  prdata = '0;
      endcase
    end
  end

  assign pready  = 1'b1;
  assign pslverr = fault & ctrl_q[0];
  assign irq     = irq_q;

  // R9
  slverr_phase_chk: assert property (@(posedge clk) disable iff (rst)
    pslverr |-> (psel && penable));
  // R9
  rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(psel && penable && !pwrite) |-> (prdata == '0));
  // R2
  ctrl_resv_chk: assert property (@(posedge clk) disable iff (rst)
    (psel && penable && !pwrite && paddr == '0) |-> (prdata[DW-1:1] == '0));
endmodule

// File: tb/addr_fault_irq_unit_tb.sv
module addr_fault_irq_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 32;

  logic clk = 0, rst = 1;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [AW-1:0] paddr = '0;
  logic [DW-1:0] pwdata = '0;
  logic [DW-1:0] prdata;
  logic pready, pslverr, irq;

  int total = 0, bad = 0;
  logic [DW-1:0] rd_val;
  logic err_val;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_fault_irq_unit #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .irq(irq)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // One APB transfer; leaves time at the negedge after the commit edge.
  task automatic xfer(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1;
    #1;
    rd_val = prdata; err_val = pslverr;
    check("R10 pready", {31'b0, pready}, 1);
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic t_reset;
    xfer(0, 12'h0, 0);  check("R1 ctrl", rd_val, 0);
    xfer(0, 12'h4, 0);  check("R1 status", rd_val, 0);
    xfer(0, 12'h8, 0);  check("R1 mask", rd_val, 1);
    check("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_ctrl;
    xfer(1, 12'h0, 32'hFFFF_FFFF);
    xfer(0, 12'h0, 0);  check("R2 ctrl rw+resv", rd_val, 1);
    xfer(1, 12'h0, 0);
    xfer(0, 12'h0, 0);  check("R2 ctrl clear", rd_val, 0);
  endtask

  task automatic t_fault_quiet;
    xfer(0, 12'h14, 0);
    check("R9 quiet slverr", {31'b0, err_val}, 0);
    check("R9 fault read data", rd_val, 0);
    xfer(0, 12'h4, 0);  check("R3 status set", rd_val, 1);
    check("R8 masked irq", {31'b0, irq}, 0);
  endtask

  task automatic t_unmask;
    xfer(1, 12'h8, 0);
    xfer(0, 12'h8, 0);  check("R5 direct write ignored", rd_val, 1);
    xfer(1, 12'hC, 0);
    xfer(0, 12'h8, 0);  check("R6 zero write no effect", rd_val, 1);
    xfer(1, 12'hC, 1);
    check("R8 irq lag", {31'b0, irq}, 0);
    @(negedge clk);
    check("R8 irq rise", {31'b0, irq}, 1);
    xfer(0, 12'h8, 0);  check("R6 mask cleared", rd_val, 0);
    xfer(0, 12'hC, 0);  check("R6 reads zero", rd_val, 0);
  endtask

  task automatic t_w1c;
    xfer(1, 12'h4, 0);
    xfer(0, 12'h4, 0);  check("R4 zero keeps", rd_val, 1);
    xfer(1, 12'h4, 1);
    check("R8 irq lag fall", {31'b0, irq}, 1);
    @(negedge clk);
    check("R8 irq fall", {31'b0, irq}, 0);
    xfer(0, 12'h4, 0);  check("R4 cleared", rd_val, 0);
  endtask

  task automatic t_fault_err;
    xfer(1, 12'h0, 1);
    xfer(1, 12'h3, 32'h1234);
    check("R9 slverr misaligned", {31'b0, err_val}, 1);
    xfer(0, 12'h4, 0);  check("R3 misaligned sets", rd_val, 1);
    check("R8 irq on", {31'b0, irq}, 1);
    xfer(0, 12'h40, 0);
    check("R9 slverr read", {31'b0, err_val}, 1);
    check("R9 err read data", rd_val, 0);
    xfer(0, 12'h4, 0);
    check("R9 no slverr mapped", {31'b0, err_val}, 0);
  endtask

  task automatic t_mask;
    xfer(1, 12'h10, 1);
    @(negedge clk);
    check("R7 irq masked", {31'b0, irq}, 0);
    xfer(0, 12'h8, 0);  check("R7 mask set", rd_val, 1);
    xfer(0, 12'h10, 0); check("R7 reads zero", rd_val, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset;
    t_ctrl;
    t_fault_quiet;
    t_unmask;
    t_w1c;
    t_fault_err;
    t_mask;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule